// File: doc/BRIEF.md
# Memory-device boundary-scan test access port

This block is the serial test port of a synchronous memory device. A tester drives a test clock, a mode-select line and a serial data input; the block walks the sixteen-state TAP controller, holds a three-bit instruction and routes one of three data registers to the serial output. The data registers are a one-bit bypass stage, a 32-bit identification word and a boundary chain whose length is a parameter. The chain samples the parallel capture inputs of the I/O ring and shifts them out; it never writes anything back to the ring.

The instruction set differs from the standard one. The all-zero code is a capture-and-float instruction. A separate code also samples the ring and floats the outputs. The sample code captures the ring but has no preload or update step. Two instructions raise a force-high-Z output toward the memory's output drivers. The array and the pad cells live elsewhere. The serial pins are a plain bit-serial interface clocked by the test clock. There is no valid/ready handshake and no back-pressure: a bit moves on every test-clock edge in a shift state.

Top module: `memtap_top`

## Requirements
- R1: The controller follows the sixteen-state TAP graph on rising test-clock edges. Five consecutive rising edges with the mode line high reach Test-Logic-Reset from any state. An asynchronous active-low power-on reset also enters Test-Logic-Reset.
- R2: In Test-Logic-Reset the active instruction becomes the identification code 001 and force-high-Z is low.
- R3: Capture-IR loads 3'b001 into the instruction shift stage, so a following Shift-IR presents 1, 0, 0 on the serial output.
- R4: The instruction shifts in least significant bit first. The new code becomes active only on the falling edge while in Update-IR; force-high-Z keeps its old value until then.
- R5: Code 001 selects the 32-bit identification register. Capture-DR loads the ID_VALUE parameter, Shift-DR presents it least significant bit first, and force-high-Z stays low.
- R6: Code 111 selects the one-bit bypass stage. It captures 0, so the serial output is 0 followed by the serial input delayed by one bit.
- R7: Code 100 selects the boundary chain. Capture-DR loads the ring inputs, bit 0 leaves first, a fresh capture happens on every pass, and force-high-Z stays low.
- R8: Code 000 captures and shifts the boundary chain as in R7 and holds force-high-Z high.
- R9: Code 010 captures and shifts the boundary chain as in R7 and holds force-high-Z high.
- R10: The unassigned codes 011, 101 and 110 act as bypass and hold force-high-Z low.
- R11: The serial output and its enable change on falling test-clock edges. The enable is high only in Shift-IR and Shift-DR. While the enable is low the serial output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| ring_in | input | BSR_LEN | Parallel capture values from the I/O ring |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Serial output enable |
| force_hiz | output | 1 | Forces the memory output drivers to high impedance |

## Verification
Two things are hard to reach from the pins. The first is the window between the end of an instruction shift and the falling edge in Update-IR, when the new code is loaded but not yet active. The stimulus stops the bench one rising edge into Update-IR and samples force-high-Z before the falling edge. The second is the Test-Logic-Reset path. The bench loads a floating instruction first and then holds the mode line high for five edges, so that the release of force-high-Z and the return to the identification code both show at the pins.

// File: rtl/memtap_pkg.sv
package memtap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_FLOATCAP = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT    = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPHIZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  typedef enum logic [1:0] {DSEL_BYP, DSEL_ID, DSEL_BSR} dsel_e;
endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
  import memtap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

  // R1: five rising edges with tms high always end in Test-Logic-Reset
  a_r1_five_high_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == ST_TLR);
endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
  import memtap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ir_sr <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  // active instruction moves on the falling edge only
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) ir_q <= OP_IDENT;
    else if (state == ST_TLR)    ir_q <= OP_IDENT;
    else if (state == ST_UPD_IR) ir_q <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];

  // R3: capture pattern lands in the shift stage
  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_CAP_IR |=> ir_sr[1:0] == 2'b01);
  // R4: instruction holds outside Update-IR and Test-Logic-Reset
  a_r4_ir_holds: assert property (@(negedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q));
  // R2: Test-Logic-Reset restores the identification code
  a_r2_tlr_ident: assert property (@(negedge tck) disable iff (!trst_n)
    state == ST_TLR |=> ir_q == OP_IDENT);
endmodule

// File: rtl/memtap_dr.sv
module memtap_dr
  import memtap_pkg::*;
#(
  parameter int          BSR_LEN  = 71,
  parameter logic [31:0] ID_VALUE = 32'h2B5A_C4E1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  dsel_e              sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] ring_in,
  output logic               dr_lsb
);
  localparam int ID_W = 32;

  logic               byp_q;
  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr;
  logic cap, sh;

  assign cap = (state == ST_CAP_DR);
  assign sh  = (state == ST_SH_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q  <= 1'b0;
      id_sr  <= ID_VALUE;
      bsr_sr <= '0;
    end else begin
      unique case (sel)
        DSEL_ID: begin
          if (cap)     id_sr <= ID_VALUE;
          else if (sh) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
        DSEL_BSR: begin
          if (cap)     bsr_sr <= ring_in;
          else if (sh) bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
        end
        default: begin
          if (cap)     byp_q <= 1'b0;
          else if (sh) byp_q <= tdi;
        end
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      DSEL_ID:  dr_lsb = id_sr[0];
      DSEL_BSR: dr_lsb = bsr_sr[0];
      default:  dr_lsb = byp_q;
    endcase
  end

  // R6: bypass stage captures zero
  a_r6_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && sel == DSEL_BYP) |=> byp_q == 1'b0);
  // R7: boundary capture takes the ring values
  a_r7_ring_capture: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && sel == DSEL_BSR) |=> bsr_sr == $past(ring_in));
endmodule

// File: rtl/memtap_top.sv
module memtap_top
  import memtap_pkg::*;
#(
  parameter int          BSR_LEN  = 71,
  parameter logic [31:0] ID_VALUE = 32'h2B5A_C4E1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] ring_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               force_hiz
);
  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb;
  dsel_e           sel;

  memtap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  memtap_ir u_ir (.tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
                  .ir_q(ir_q), .ir_lsb(ir_lsb));

  always_comb begin
    unique case (ir_q)
      OP_IDENT:                          sel = DSEL_ID;
      OP_FLOATCAP, OP_SAMPHIZ, OP_SAMPLE: sel = DSEL_BSR;
      default:                           sel = DSEL_BYP;
    endcase
  end

  assign force_hiz = (ir_q == OP_FLOATCAP) || (ir_q == OP_SAMPHIZ);

  memtap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(state), .sel(sel), .tdi(tdi),
    .ring_in(ring_in), .dr_lsb(dr_lsb));

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR)      tdo <= ir_lsb;
      else if (state == ST_SH_DR) tdo <= dr_lsb;
      else                        tdo <= 1'b0;
    end
  end

  // R11: output enable only while a shift state is current
  a_r11_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
  // R11: quiet output when disabled
  a_r11_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> !tdo);
  // R2: leaving Test-Logic-Reset the drivers are released
  a_r2_hiz_release: assert property (@(negedge tck) disable iff (!trst_n)
    state == ST_TLR |=> !force_hiz);
endmodule

// File: tb/test_memtap_top.sv
module test_memtap_top;
  localparam int          L   = 71;
  localparam logic [31:0] IDV = 32'h2B5A_C4E1;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [L-1:0] ring = '0;
  logic tdo, tdo_oe, force_hiz;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic v; int r; } exp_t;
  exp_t q[$];

  memtap_top #(.BSR_LEN(L), .ID_VALUE(IDV)) i_memtap_top (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .ring_in(ring),
    .tdo(tdo), .tdo_oe(tdo_oe), .force_hiz(force_hiz));

  always #2 tck = ~tck;

  task automatic chk(bit ok, int r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic push(logic v, int r);
    exp_t e;
    e.v = v; e.r = r;
    q.push_back(e);
  endtask

  // scoreboard monitor: one serial bit per falling edge with the enable high
  always @(negedge tck) begin
    #2;
    if (tdo_oe && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(tdo === e.v, e.r, "tdo bit", {31'b0, tdo}, {31'b0, e.v});
    end
  end

  task automatic step(logic m, logic d);
    @(negedge tck);
    #1; tms = m; tdi = d;
  endtask

  // from Run-Test/Idle: load code, check capture pattern and update timing
  task automatic load_ir(logic [2:0] code, logic old_hiz, logic new_hiz, int r);
    push(1'b1, 3); push(1'b0, 3); push(1'b0, 3);   // R3 capture pattern
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, code[i]);
    step(1, 0);
    @(posedge tck); #1;
    chk(force_hiz === old_hiz, 4, "hiz before update falling edge (R4)",
        {31'b0, force_hiz}, {31'b0, old_hiz});
    step(0, 0);
    chk(force_hiz === new_hiz, r, "hiz after update", {31'b0, force_hiz}, {31'b0, new_hiz});
  endtask

  task automatic shift_dr(int n, logic [127:0] din);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic expect_ring(logic [L-1:0] v, int r);
    for (int i = 0; i < L; i++) push(v[i], r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] bp;
    repeat (3) @(negedge tck);
    #1;
    chk(force_hiz === 1'b0, 2, "hiz in reset", {31'b0, force_hiz}, 32'd0);
    chk(tdo_oe === 1'b0, 11, "oe in reset", {31'b0, tdo_oe}, 32'd0);
    trst_n = 1'b1;
    step(0, 0);                              // to Run-Test/Idle
    @(negedge tck); #1;
    chk(tdo_oe === 1'b0 && tdo === 1'b0, 11, "idle output quiet",
        {30'b0, tdo_oe, tdo}, 32'd0);

    // R5: identification code is active after reset (R2)
    for (int i = 0; i < 32; i++) push(IDV[i], 5);
    shift_dr(32, '0);
    chk(force_hiz === 1'b0, 5, "hiz under ident", {31'b0, force_hiz}, 32'd0);

    // R6: bypass delays tdi by one bit
    load_ir(3'b111, 1'b0, 1'b0, 6);
    bp = 8'b1011_0010;
    push(1'b0, 6);
    for (int i = 1; i < 8; i++) push(bp[i-1], 6);
    shift_dr(8, {120'b0, bp});

    // R7: sample captures ring, fresh on each pass, no floating
    load_ir(3'b100, 1'b0, 1'b0, 7);
    ring = {7'h55, 32'hDEAD_BEEF, 32'h0F0F_1234};
    expect_ring(ring, 7);
    shift_dr(L, '1);
    ring = {7'h2A, 32'h1357_9BDF, 32'hFACE_0001};
    expect_ring(ring, 7);
    shift_dr(L, '0);

    // R8: all-zero code floats and captures
    load_ir(3'b000, 1'b0, 1'b1, 8);
    ring = {7'h01, 32'h8000_0001, 32'hC3C3_3C3C};
    expect_ring(ring, 8);
    shift_dr(L, '0);

    // R9: sample with high-Z
    load_ir(3'b010, 1'b1, 1'b1, 9);
    ring = {7'h7F, 32'h0000_FFFF, 32'hA5A5_5A5A};
    expect_ring(ring, 9);
    shift_dr(L, '0);

    // R10: unassigned codes act as bypass with drivers released
    load_ir(3'b011, 1'b1, 1'b0, 10);
    push(1'b0, 10); push(1'b1, 10); push(1'b1, 10); push(1'b0, 10);
    shift_dr(4, 128'b0011);
    load_ir(3'b101, 1'b0, 1'b0, 10);
    push(1'b0, 10); push(1'b1, 10);
    shift_dr(2, 128'b01);
    load_ir(3'b110, 1'b0, 1'b0, 10);
    push(1'b0, 10); push(1'b0, 10);
    shift_dr(2, 128'b10);

    // R1: five high edges reset the controller; R2 restores ident
    load_ir(3'b000, 1'b0, 1'b1, 8);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    chk(force_hiz === 1'b0, 2, "hiz after tms reset (R1)", {31'b0, force_hiz}, 32'd0);
    for (int i = 0; i < 32; i++) push(IDV[i], 1);
    shift_dr(32, '0);

    repeat (3) @(negedge tck);
    chk(q.size() == 0, 11, "scoreboard drained", q.size(), 32'd0);
    finish_run();
  end
endmodule